// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two double-precision binary floating-point operands and reports their relation as a one-hot four-bit condition code: less, greater, equal or unordered. It serves both the quiet (unordered) compare and the ordered compare. The two differ only in how they report an invalid operation when a NaN is present.

Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A single unsigned compare of the exponent-and-fraction field then orders all non-NaN magnitudes, subnormals included, without flushing them to zero. Sign rules on top of that compare settle the final relation.

Two flags come out next to the condition code. One marks a signalling NaN operand. The other marks an invalid ordered compare. All results are registered and appear one clock after the input strobe.

Top module: `fpcmp_unit`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, `out_valid`, `cond_code`, `flag_snan` and `flag_invcmp` are all 0 after that edge.
- R2: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is 0, `cond_code` and both flags keep their previous values.
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), `cond_code` is 4'b0001, the unordered code. Code bits from MSB to LSB are {less, greater, equal, unordered}.
- R4: `flag_snan` is 1 exactly when either operand is a signalling NaN. A signalling NaN has exponent all ones, a nonzero fraction and fraction bit 51 equal to 0. This holds in both modes.
- R5: With `ordered_mode`=1 and a NaN operand, `flag_invcmp` is 1 when either operand is a quiet NaN (fraction bit 51 = 1) or when `inv_enable`=1. Otherwise it is 0.
- R6: With `ordered_mode`=0, `flag_invcmp` is 0 whatever the operands and `inv_enable`.
- R7: Two zeros compare equal (4'b0010) whatever their signs.
- R8: When the signs differ and the operands are not both zero, the negative operand is less. The code is 4'b1000 if a is negative and 4'b0100 if b is negative.
- R9: For equal signs, magnitudes order as infinity > finite nonzero > zero, and finite values order by exact magnitude. The less/greater result is swapped when both operands are negative.
- R10: Two infinities of the same sign compare equal.
- R11: Subnormal operands are compared exactly and are never treated as zero.
- R12: Every valid result has exactly one `cond_code` bit set. Both flags are 0 when neither operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: operands and mode are sampled this cycle |
| opnd_a | input | 64 | First operand, double precision |
| opnd_b | input | 64 | Second operand, double precision |
| ordered_mode | input | 1 | 1 selects the ordered compare |
| inv_enable | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| cond_code | output | 4 | One-hot {less, greater, equal, unordered} |
| flag_snan | output | 1 | Signalling NaN operand seen |
| flag_invcmp | output | 1 | Invalid ordered compare |

## Verification
The assertions assume the operands, `ordered_mode` and `inv_enable` are stable and fully known (no X bits) in every cycle where `in_valid` is high. They also assume `rst` is held high from time zero until the first clock edge. The bench meets these assumptions by driving every input only at the falling clock edge and holding each set of operands for one whole cycle. It also starts in reset and only releases it after two edges. Between strobes the bench changes the operands while `in_valid` is low, which checks the hold behaviour without breaking the stability assumption in strobe cycles.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int WORD_W = 1 + MAG_W;
    localparam int CC_W   = 4;

    // condition code positions: {less, greater, equal, unordered}
    localparam logic [CC_W-1:0] CC_LT = 4'b1000;
    localparam logic [CC_W-1:0] CC_GT = 4'b0100;
    localparam logic [CC_W-1:0] CC_EQ = 4'b0010;
    localparam logic [CC_W-1:0] CC_UN = 4'b0001;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fp_class_e;

    typedef struct packed {
        logic             sign;
        fp_class_e        cls;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

    typedef struct packed {
        logic            valid;
        logic [CC_W-1:0] cc;
        logic            snan;
        logic            invcmp;
    } result_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output opnd_info_t        info_o
);
    logic [EXP_W-1:0]  exp_w;
    logic [FRAC_W-1:0] frac_w;

    assign exp_w  = word_i[MAG_W-1:FRAC_W];
    assign frac_w = word_i[FRAC_W-1:0];

    always_comb begin
        info_o.sign = word_i[WORD_W-1];
        info_o.mag  = word_i[MAG_W-1:0];
        if (exp_w == '1) begin
            if (frac_w == '0)
                info_o.cls = CLS_INF;
            else if (frac_w[FRAC_W-1])
                info_o.cls = CLS_QNAN;
            else
                info_o.cls = CLS_SNAN;
        end else if (exp_w == '0) begin
            info_o.cls = (frac_w == '0) ? CLS_ZERO : CLS_SUB;
        end else begin
            info_o.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpcmp_magnitude.sv
module fpcmp_magnitude #(
    parameter int W = 63
) (
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic         a_lt_b_o,
    output logic         a_eq_b_o
);
    // exponent above fraction makes unsigned order equal magnitude order
    assign a_lt_b_o = (mag_a_i < mag_b_i);
    assign a_eq_b_o = (mag_a_i == mag_b_i);
endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
    import fpcmp_pkg::*;
(
    input  opnd_info_t      a_i,
    input  opnd_info_t      b_i,
    input  logic            mag_lt_i,
    input  logic            mag_eq_i,
    input  logic            ordered_i,
    input  logic            inv_en_i,
    output logic [CC_W-1:0] cc_o,
    output logic            snan_o,
    output logic            invcmp_o
);
    logic a_snan, b_snan, a_qnan, b_qnan, any_nan, both_zero, lt_signed;

    always_comb begin
        a_snan    = (a_i.cls == CLS_SNAN);
        b_snan    = (b_i.cls == CLS_SNAN);
        a_qnan    = (a_i.cls == CLS_QNAN);
        b_qnan    = (b_i.cls == CLS_QNAN);
        any_nan   = a_snan | b_snan | a_qnan | b_qnan;
        both_zero = (a_i.cls == CLS_ZERO) && (b_i.cls == CLS_ZERO);
        lt_signed = a_i.sign ? ~mag_lt_i : mag_lt_i;

        cc_o     = CC_UN;
        snan_o   = 1'b0;
        invcmp_o = 1'b0;
        if (any_nan) begin
            snan_o   = a_snan | b_snan;
            invcmp_o = ordered_i & (inv_en_i | a_qnan | b_qnan);
        end else if (both_zero) begin
            cc_o = CC_EQ;
        end else if (a_i.sign != b_i.sign) begin
            cc_o = a_i.sign ? CC_LT : CC_GT;
        end else if (mag_eq_i) begin
            cc_o = CC_EQ;
        end else begin
            cc_o = lt_signed ? CC_LT : CC_GT;
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic              ordered_mode,
    input  logic              inv_enable,
    output logic              out_valid,
    output logic [CC_W-1:0]   cond_code,
    output logic              flag_snan,
    output logic              flag_invcmp
);
    opnd_info_t        info [2];
    logic [WORD_W-1:0] words [2];
    logic              mag_lt, mag_eq;
    logic [CC_W-1:0]   cc_w;
    logic              snan_w, invcmp_w;
    result_t           res_d, res_q;

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpcmp_classify u_cls (
            .word_i (words[gi]),
            .info_o (info[gi])
        );
    end

    fpcmp_magnitude #(.W(MAG_W)) u_mag (
        .mag_a_i  (info[0].mag),
        .mag_b_i  (info[1].mag),
        .a_lt_b_o (mag_lt),
        .a_eq_b_o (mag_eq)
    );

    fpcmp_decide u_dec (
        .a_i       (info[0]),
        .b_i       (info[1]),
        .mag_lt_i  (mag_lt),
        .mag_eq_i  (mag_eq),
        .ordered_i (ordered_mode),
        .inv_en_i  (inv_enable),
        .cc_o      (cc_w),
        .snan_o    (snan_w),
        .invcmp_o  (invcmp_w)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.cc     = cc_w;
            res_d.snan   = snan_w;
            res_d.invcmp = invcmp_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign cond_code   = res_q.cc;
    assign flag_snan   = res_q.snan;
    assign flag_invcmp = res_q.invcmp;
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk
    import fpcmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic              ordered_mode,
    input logic              out_valid,
    input logic [CC_W-1:0]   cond_code,
    input logic              flag_snan,
    input logic              flag_invcmp
);
    logic a_nan, b_nan;
    assign a_nan = (opnd_a[MAG_W-1:FRAC_W] == '1) && (opnd_a[FRAC_W-1:0] != '0);
    assign b_nan = (opnd_b[MAG_W-1:FRAC_W] == '1) && (opnd_b[FRAC_W-1:0] != '0);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && cond_code == '0 && !flag_snan && !flag_invcmp));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(cond_code) && $stable(flag_snan)));

    assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_nan || b_nan)) |=> (cond_code == CC_UN));

    assert_snan_implies_un_R4: assert property (@(posedge clk) disable iff (rst)
        flag_snan |-> cond_code == CC_UN);

    assert_invcmp_implies_un_R5: assert property (@(posedge clk) disable iff (rst)
        flag_invcmp |-> cond_code == CC_UN);

    assert_unordered_no_inv_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ordered_mode) |=> !flag_invcmp);

    assert_zeros_equal_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opnd_a[MAG_W-1:0] == '0 && opnd_b[MAG_W-1:0] == '0)
        |=> (cond_code == CC_EQ));

    assert_onehot_cc_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(cond_code) == 1));
endmodule

bind fpcmp_unit fpcmp_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .ordered_mode (ordered_mode),
    .out_valid    (out_valid),
    .cond_code    (cond_code),
    .flag_snan    (flag_snan),
    .flag_invcmp  (flag_invcmp)
);

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic        ord;
        logic        ve;
        logic [3:0]  cc;
        logic        snan;
        logic        inv;
        logic [4:0]  req;
    } vec_t;

    localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
    localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
    localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
    localparam logic [63:0] PI = 64'h7FF0000000000000, NI = 64'hFFF0000000000000;
    localparam logic [63:0] QN = 64'h7FF8000000000000, NQ = 64'hFFF8000000000000;
    localparam logic [63:0] SN = 64'h7FF0000000000001;
    localparam logic [63:0] D1 = 64'h0000000000000001, D2 = 64'h0000000000000002;
    localparam logic [63:0] DM = 64'h000FFFFFFFFFFFFF, MN = 64'h0010000000000000;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{P1, P2, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd9},  // R9 1<2
        '{P2, P1, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 5'd9},  // R9
        '{N1, N2, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 5'd9},  // R9 negatives swapped
        '{N2, N1, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd9},  // R9
        '{P1, P1, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, 5'd9},  // R9 equal
        '{PZ, NZ, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, 5'd7},  // R7
        '{NZ, PZ, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 5'd7},  // R7
        '{NZ, P1, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd8},  // R8
        '{N1, PZ, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd8},  // R8
        '{P1, NI, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 5'd8},  // R8
        '{PI, PI, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, 5'd10}, // R10
        '{NI, NI, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 5'd10}, // R10
        '{PI, P2, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 5'd9},  // R9 inf above finite
        '{NI, N2, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd9},  // R9
        '{D1, D2, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd11}, // R11
        '{DM, MN, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 5'd11}, // R11
        '{D1, PZ, 1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 5'd11}, // R11 no flush
        '{QN, P1, 1'b0, 1'b0, 4'h1, 1'b0, 1'b0, 5'd3},  // R3
        '{QN, P1, 1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 5'd5},  // R5 quiet NaN ordered
        '{SN, P1, 1'b0, 1'b1, 4'h1, 1'b1, 1'b0, 5'd4},  // R4 and R6
        '{SN, P1, 1'b1, 1'b0, 4'h1, 1'b1, 1'b0, 5'd5},  // R5 snan only, enable off
        '{P1, SN, 1'b1, 1'b1, 4'h1, 1'b1, 1'b1, 5'd5},  // R5 enable on
        '{P1, QN, 1'b0, 1'b1, 4'h1, 1'b0, 1'b0, 5'd6},  // R6
        '{P1, P2, 1'b1, 1'b1, 4'h8, 1'b0, 1'b0, 5'd12}, // R12 no flags
        '{NQ, SN, 1'b1, 1'b0, 4'h1, 1'b1, 1'b1, 5'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        ordered_mode = 1'b0, inv_enable = 1'b0;
    logic        out_valid, flag_snan, flag_invcmp;
    logic [3:0]  cond_code;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcmp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ordered_mode(ordered_mode), .inv_enable(inv_enable),
        .out_valid(out_valid), .cond_code(cond_code),
        .flag_snan(flag_snan), .flag_invcmp(flag_invcmp)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic ord, input logic ve);
        @(negedge clk);
        opnd_a = a; opnd_b = b; ordered_mode = ord; inv_enable = ve;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 out_valid", {3'b0, out_valid}, 4'h0);
        check("R1 cond_code", cond_code, 4'h0);
        check("R1 flags", {2'b0, flag_snan, flag_invcmp}, 4'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i].a, VEC[i].b, VEC[i].ord, VEC[i].ve);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check({tag, " cc"}, cond_code, VEC[i].cc);
            check({tag, " snan"}, {3'b0, flag_snan}, {3'b0, VEC[i].snan});
            check({tag, " invcmp"}, {3'b0, flag_invcmp}, {3'b0, VEC[i].inv});
            check("R2 out_valid one cycle after strobe", {3'b0, out_valid}, 4'h1);
        end

        // R2: valid drops and results hold while idle with changed operands
        apply(P2, P1, 1'b0, 1'b0);
        opnd_a = SN; opnd_b = QN; ordered_mode = 1'b1; inv_enable = 1'b1;
        @(negedge clk);
        check("R2 out_valid low when idle", {3'b0, out_valid}, 4'h0);
        check("R2 cc held when idle", cond_code, 4'h4);
        check("R2 flags held when idle", {2'b0, flag_snan, flag_invcmp}, 4'h0);

        // R1: reset in mid-run clears a NaN result
        apply(SN, QN, 1'b1, 1'b1);
        check("R4 pre-reset snan", {3'b0, flag_snan}, 4'h1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run cc", cond_code, 4'h0);
        check("R1 mid-run flags", {2'b0, flag_snan, flag_invcmp}, 4'h0);
        rst = 1'b0;

        // R8: negative b with positive zero a
        apply(PZ, N2, 1'b0, 1'b0);
        check("R8 +0 vs -2", cond_code, 4'h4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule